// File: doc/BRIEF.md
# Aligned Half-Block Instruction Fetch Unit

This block is the front of a two-wide pipeline. It keeps the fetch address and requests instructions from an instruction cache whose lines are four instructions long. The cache returns one aligned half-line per request: two adjacent 32-bit instructions, with the lower address in slot 0. The block registers each returned pair and presents it to decode as two slots, each with a valid bit. A fetch never crosses a half-line boundary. When a jump lands on the second word of a half-line, the whole pair is still fetched, but slot 0 is marked invalid. That slot is lost bandwidth.

Decode resolves jumps and sends the jump target back on the redirect inputs in the cycle in which it accepts the pair that holds the jump. The block predecodes each returned pair. When slot 0 holds a jump, the instruction that follows it in slot 1 is dropped. When slot 1 holds a jump, an output tells the issue logic to route slot 1 to pipe A, the only pipe that runs jumps. A stall input from decode freezes the presented pair. Any response arriving during a stall is discarded and fetched again afterwards.

The controller has three states. BOOT is the single cycle after reset, in which no request is made; it always moves to PAUSE. PAUSE means no response is expected: without a stall the block issues a request and moves to STREAM, and with a stall it stays in PAUSE. STREAM means a response is arriving: without a stall the block captures it (unless a redirect is taken) and issues the next request, staying in STREAM; with a stall it drops the response, rewinds the fetch address to it, and moves to PAUSE.

Top module: `hbf_fetch_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both slots are invalid and no request is made. The next cycle requests address 0.
- R2: A request that directly follows a request, with no redirect taken in the current cycle, is to the previous address plus 8. A pair appears on the slot outputs two cycles after its request, with `pair_pc_o` equal to the request address and slot 0 holding the word at that address.
- R3: Every request address has bits [2:0] equal to zero, so no fetch straddles two half-lines.
- R4: A redirect is taken in any cycle with `stall_i` low. Targets are word aligned (bits [1:0] zero). A request to the target with bits [2:0] cleared is issued in that same cycle, and when the target's bit 2 is 0, slot 0 of the delivered pair is valid.
- R5: When the target's bit 2 is 1, slot 0 of the delivered target pair is invalid and slot 1 holds the target instruction.
- R6: The pair arriving in the cycle a redirect is taken is discarded, so both slots are invalid in the following cycle.
- R7: A jump is a word whose bits [6:0] equal 7'h6F. A valid slot 0 holding a jump is always presented with slot 1 invalid.
- R8: `pipe_a_slot_o` is 1 exactly when slot 1 is valid and holds a jump, and 0 otherwise.
- R9: In the cycle after a cycle with `stall_i` high, all slot outputs are unchanged. No request is issued in a cycle with `stall_i` high.
- R10: After a stall, fetching resumes at the pair whose response was dropped, with the same slot 0 validity, so decode receives every instruction of the program path exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Decode did not accept the presented pair this cycle |
| redir_valid_i | input | 1 | Jump target is valid this cycle |
| redir_target_i | input | AW | Jump target byte address |
| req_valid_o | output | 1 | Cache read request |
| req_addr_o | output | AW | Half-line aligned cache read address |
| rsp_data_i | input | 2*IW | Pair read one cycle after the request, slot 0 in the low half |
| slot_valid_o | output | 2 | Per-slot valid bits |
| slot_instr_o | output | 2*IW | Presented pair, slot 0 in the low half |
| pair_pc_o | output | AW | Address of slot 0 of the presented pair |
| pipe_a_slot_o | output | 1 | 1 when slot 1 must issue to pipe A |

## Verification
A program path mixes straight-line code with jumps to an aligned target, to the second word of a half-line, and to a pair in which the jump is itself in slot 0 or in slot 1. This separates the unaligned-target case from the aligned one, and a slot 0 kill from a pipe A swap. The path is run once with no stalls, to pin down the request-to-output latency and the one-cycle redirect bubble. It is then run with a periodic stall pattern that lands stalls on responses in flight, including a target response. This shows whether a dropped pair is fetched again once, with its slot validity intact, rather than lost or repeated.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_PAUSE  = 2'd1,
        ST_STREAM = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/hbf_predecode.sv
module hbf_predecode #(
    parameter int OPC_W = 7,
    parameter logic [OPC_W-1:0] JUMP_OPC = 7'h6F
) (
    input  logic [OPC_W-1:0] opc_i,
    output logic             is_jump_o
);

    assign is_jump_o = (opc_i == JUMP_OPC);

endmodule

// File: rtl/hbf_ctrl.sv
module hbf_ctrl
    import hbf_pkg::*;
#(
    parameter int AW          = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall_i,
    input  logic          redir_valid_i,
    input  logic [AW-1:0] redir_target_i,
    output logic          req_valid_o,
    output logic [AW-1:0] req_addr_o,
    output logic          load_o,
    output logic [AW-1:0] load_pc_o,
    output logic          load_skip_o
);

    localparam int HB_BYTES = 2 * INSTR_BYTES;
    localparam int OFF_W    = $clog2(HB_BYTES);
    localparam int SLOT_BIT = $clog2(INSTR_BYTES);
    localparam logic [AW-1:0] HB_STEP = AW'(HB_BYTES);

    fetch_state_e state_q, state_d;
    logic [AW-1:0] fetch_pc_q, fetch_pc_d, infl_pc_q;
    logic          fetch_skip_q, fetch_skip_d, infl_skip_q;
    logic          redir_take, issue_skip;
    logic [AW-1:0] tgt_al, issue_pc;

    assign redir_take = redir_valid_i && !stall_i;
    assign tgt_al     = {redir_target_i[AW-1:OFF_W], {OFF_W{1'b0}}};
    assign issue_pc   = redir_take ? tgt_al : fetch_pc_q;
    assign issue_skip = redir_take ? redir_target_i[SLOT_BIT] : fetch_skip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        req_valid_o  = 1'b0;
        load_o       = 1'b0;
        fetch_pc_d   = fetch_pc_q;
        fetch_skip_d = fetch_skip_q;
        unique case (state_q)
            ST_BOOT: begin
                state_d = ST_PAUSE;
                if (redir_take) begin
                    fetch_pc_d   = tgt_al;
                    fetch_skip_d = redir_target_i[SLOT_BIT];
                end
            end
            ST_PAUSE: begin
                if (!stall_i) begin
                    req_valid_o = 1'b1;
                    state_d     = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (stall_i) begin
                    fetch_pc_d   = infl_pc_q;
                    fetch_skip_d = infl_skip_q;
                    state_d      = ST_PAUSE;
                end else begin
                    req_valid_o = 1'b1;
                    load_o      = !redir_take;
                end
            end
            default: state_d = ST_BOOT;
        endcase
        if (req_valid_o) begin
            fetch_pc_d   = issue_pc + HB_STEP;
            fetch_skip_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_pc_q   <= '0;
            fetch_skip_q <= 1'b0;
            infl_pc_q    <= '0;
            infl_skip_q  <= 1'b0;
        end else begin
            fetch_pc_q   <= fetch_pc_d;
            fetch_skip_q <= fetch_skip_d;
            if (req_valid_o) begin
                infl_pc_q   <= issue_pc;
                infl_skip_q <= issue_skip;
            end
        end
    end

    assign req_addr_o  = issue_pc;
    assign load_pc_o   = infl_pc_q;
    assign load_skip_o = infl_skip_q;

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_addr_o[OFF_W-1:0] == '0)); // R3
    AST_NO_REQ_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !req_valid_o); // R9
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && $past(req_valid_o) && !redir_take)
            |-> (req_addr_o == $past(req_addr_o) + HB_STEP)); // R2
    AST_TARGET_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_i |-> (redir_target_i[SLOT_BIT-1:0] == '0)); // R4

endmodule

// File: rtl/hbf_slot_reg.sv
module hbf_slot_reg #(
    parameter int AW = 32,
    parameter int IW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic            load_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [2*IW-1:0] instr_i,
    input  logic [1:0]      valid_i,
    input  logic            asel_i,
    output logic [AW-1:0]   pc_o,
    output logic [2*IW-1:0] instr_o,
    output logic [1:0]      valid_o,
    output logic            asel_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_o    <= '0;
            instr_o <= '0;
            valid_o <= 2'b00;
            asel_o  <= 1'b0;
        end else if (!hold_i) begin
            if (load_i) begin
                pc_o    <= pc_i;
                instr_o <= instr_i;
                valid_o <= valid_i;
                asel_o  <= asel_i;
            end else begin
                valid_o <= 2'b00;
                asel_o  <= 1'b0;
            end
        end
    end

    AST_ASEL_NEEDS_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
        asel_o |-> valid_o[1]); // R8

endmodule

// File: rtl/hbf_fetch_unit.sv
module hbf_fetch_unit #(
    parameter int AW          = 32,
    parameter int IW          = 32,
    parameter int INSTR_BYTES = 4,
    parameter int OPC_W       = 7,
    parameter logic [OPC_W-1:0] JUMP_OPC = 7'h6F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            redir_valid_i,
    input  logic [AW-1:0]   redir_target_i,
    output logic            req_valid_o,
    output logic [AW-1:0]   req_addr_o,
    input  logic [2*IW-1:0] rsp_data_i,
    output logic [1:0]      slot_valid_o,
    output logic [2*IW-1:0] slot_instr_o,
    output logic [AW-1:0]   pair_pc_o,
    output logic            pipe_a_slot_o
);

    localparam int SLOTS = 2;

    logic          load, load_skip, asel_in;
    logic [AW-1:0] load_pc;
    logic [SLOTS-1:0] jmp, v_in;

    hbf_ctrl #(.AW(AW), .INSTR_BYTES(INSTR_BYTES)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall_i        (stall_i),
        .redir_valid_i  (redir_valid_i),
        .redir_target_i (redir_target_i),
        .req_valid_o    (req_valid_o),
        .req_addr_o     (req_addr_o),
        .load_o         (load),
        .load_pc_o      (load_pc),
        .load_skip_o    (load_skip)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_pd
        hbf_predecode #(.OPC_W(OPC_W), .JUMP_OPC(JUMP_OPC)) u_pd (
            .opc_i     (rsp_data_i[g*IW +: OPC_W]),
            .is_jump_o (jmp[g])
        );
    end

    assign v_in[0] = !load_skip;
    assign v_in[1] = !(v_in[0] && jmp[0]);
    assign asel_in = v_in[1] && jmp[1];

    hbf_slot_reg #(.AW(AW), .IW(IW)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (stall_i),
        .load_i  (load),
        .pc_i    (load_pc),
        .instr_i (rsp_data_i),
        .valid_i (v_in),
        .asel_i  (asel_in),
        .pc_o    (pair_pc_o),
        .instr_o (slot_instr_o),
        .valid_o (slot_valid_o),
        .asel_o  (pipe_a_slot_o)
    );

    AST_JUMP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid_o[0] && slot_instr_o[OPC_W-1:0] == JUMP_OPC) |-> !slot_valid_o[1]); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(slot_valid_o) && $stable(slot_instr_o) && $stable(pair_pc_o))); // R9
    AST_REDIR_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid_i && !stall_i) |=> (slot_valid_o == 2'b00)); // R6

endmodule

// File: tb/tb_hbf_fetch_unit.sv
`timescale 1ns/1ps
module tb_hbf_fetch_unit;

    localparam int AW = 32;
    localparam int IW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stall_i = 1'b0;
    logic            redir_valid_i = 1'b0;
    logic [AW-1:0]   redir_target_i = '0;
    logic            req_valid_o;
    logic [AW-1:0]   req_addr_o;
    logic [2*IW-1:0] rsp_data_i = '0;
    logic [1:0]      slot_valid_o;
    logic [2*IW-1:0] slot_instr_o;
    logic [AW-1:0]   pair_pc_o;
    logic            pipe_a_slot_o;

    always #10 clk = ~clk;

    hbf_fetch_unit dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .redir_valid_i(redir_valid_i), .redir_target_i(redir_target_i),
        .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .rsp_data_i(rsp_data_i), .slot_valid_o(slot_valid_o),
        .slot_instr_o(slot_instr_o), .pair_pc_o(pair_pc_o),
        .pipe_a_slot_o(pipe_a_slot_o)
    );

    function automatic logic [IW-1:0] jump_word(logic [AW-1:0] t);
        return {t[24:0], 7'h6F};
    endfunction

    function automatic logic [IW-1:0] mem_word(logic [AW-1:0] a);
        case (a)
            32'h008: return jump_word(32'h104);
            32'h10C: return jump_word(32'h208);
            32'h208: return jump_word(32'h30C);
            default: return {a[24:0], 7'h13};
        endcase
    endfunction

    function automatic bit is_jump(logic [IW-1:0] w);
        return w[6:0] == 7'h6F;
    endfunction

    function automatic logic [AW-1:0] jump_tgt(logic [IW-1:0] w);
        return {7'b0, w[31:7]};
    endfunction

    always_ff @(posedge clk)
        if (req_valid_o) rsp_data_i <= {mem_word(req_addr_o + 32'd4), mem_word(req_addr_o)};

    int checks = 0;
    int fails = 0;
    logic [AW-1:0] exp_q[$];

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push_program(int n);
        logic [AW-1:0] pc = '0;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(pc);
            if (is_jump(mem_word(pc))) pc = jump_tgt(mem_word(pc));
            else pc = pc + 32'd4;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; stall_i = 1'b0; redir_valid_i = 1'b0; redir_target_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(slot_valid_o == 2'b00 && !req_valid_o, "R1 reset state", {slot_valid_o, req_valid_o}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic run_phase(bit with_stall, int n, string ptag);
        int k = 0;
        bit prev_stall = 0, r1 = 0, r2 = 0, st, rd;
        logic [AW-1:0] t1 = '0, t2 = '0, tgt, e;
        logic [1:0] sv_v; logic [2*IW-1:0] sv_i; logic [AW-1:0] sv_pc; logic sv_a;
        logic [IW-1:0] w;
        push_program(n);
        while (exp_q.size() > 0 && k < 3000) begin
            @(negedge clk);
            if (prev_stall)
                check(slot_valid_o == sv_v && slot_instr_o == sv_i && pair_pc_o == sv_pc && pipe_a_slot_o == sv_a,
                      "R9 hold under stall", {62'b0, slot_valid_o}, {62'b0, sv_v});
            if (!with_stall && r1)
                check(slot_valid_o == 2'b00, "R6 bubble after redirect", slot_valid_o, 0);
            if (!with_stall && r2) begin
                check(pair_pc_o == {t2[AW-1:3], 3'b000}, "R4 target pair address", pair_pc_o, {t2[AW-1:3], 3'b000});
                if (t2[2]) check(slot_valid_o[0] == 1'b0, "R5 unaligned target slot0 invalid", slot_valid_o, 0);
                else       check(slot_valid_o[0] == 1'b1, "R4 aligned target slot0 valid", slot_valid_o, 1);
            end
            if (!with_stall && k == 3)
                check(pair_pc_o == 0 && slot_valid_o == 2'b11, "R2 first pair latency", {pair_pc_o, 30'b0, slot_valid_o}, 3);
            if (slot_valid_o[0] && is_jump(slot_instr_o[IW-1:0]))
                check(!slot_valid_o[1], "R7 slot1 killed after jump", slot_valid_o, 1);
            check(pipe_a_slot_o == (slot_valid_o[1] && is_jump(slot_instr_o[2*IW-1:IW])),
                  "R8 pipe A select", pipe_a_slot_o, slot_valid_o[1] && is_jump(slot_instr_o[2*IW-1:IW]));
            st = with_stall && k >= 4 && (k % 4 == 1 || k % 7 == 3);
            rd = 0; tgt = '0;
            if (!st) begin
                for (int s = 0; s < 2; s++) begin
                    if (slot_valid_o[s] && exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        w = slot_instr_o[s*IW +: IW];
                        check(pair_pc_o + 32'(4 * s) == e && w == mem_word(e),
                              with_stall ? "R10 stream order after stalls" : "R2 stream order",
                              {pair_pc_o + 32'(4 * s), w}, {e, mem_word(e)});
                        if (is_jump(w)) begin rd = 1; tgt = jump_tgt(w); end
                    end
                end
            end
            sv_v = slot_valid_o; sv_i = slot_instr_o; sv_pc = pair_pc_o; sv_a = pipe_a_slot_o;
            stall_i = st; redir_valid_i = rd; redir_target_i = tgt;
            #1;
            if (k == 0) check(!req_valid_o, "R1 no request in first cycle", req_valid_o, 0);
            if (k == 1) check(req_valid_o && req_addr_o == 0, "R1 first request at 0", req_addr_o, 0);
            if (req_valid_o) check(req_addr_o[2:0] == 3'b000, "R3 aligned request", req_addr_o, 0);
            if (st) check(!req_valid_o, "R9 no request during stall", req_valid_o, 0);
            if (rd) check(req_valid_o && req_addr_o == {tgt[AW-1:3], 3'b000}, "R4 redirect request",
                          req_addr_o, {tgt[AW-1:3], 3'b000});
            r2 = r1; t2 = t1; r1 = rd; t1 = tgt;
            prev_stall = st;
            k++;
        end
        check(exp_q.size() == 0, {ptag, " watchdog"}, exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        stall_i = 1'b0; redir_valid_i = 1'b0; redir_target_i = '0;
    endtask

    initial begin
        do_reset();
        run_phase(1'b0, 16, "R2");
        do_reset();
        run_phase(1'b1, 16, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule